// File: doc/BRIEF.md
# PLL Power-Up Sequencer

This block steps a phase-locked loop through its start-up in a fixed, timed order and shuts it down in one step. It drives a four-bit PLL control word and a ready flag. All timing comes from a reference-rate control clock. Wait times are given in microseconds and scaled by a cycles-per-microsecond parameter.

A one-cycle enable request starts the bring-up from the off state. The block first takes the PLL out of bypass. After the bypass dwell it releases the active-low PLL reset. After the lock dwell it turns on the PLL output and raises ready. Lock is not measured; it is assumed once the lock dwell has passed.

A disable request clears the whole control word at once, from any state. This includes a bring-up still in progress. Enable requests that arrive while a bring-up is running, or while the PLL is already on, change nothing.

Top module: `pll_pwrseq`

## Requirements
- R1: Synchronous reset (`rst_i` high at a clock edge) sets `pll_ctl_o` to 4'b0000 and `ready_o` to 0 at that edge, whatever the state.
- R2: In the off state, an enable request sampled at an edge sets bit 1 (bypass-off) at that edge. Bits 0 and 2 stay low.
- R3: Bit 2 (active-low PLL reset, high means released) rises exactly BYP_US*CYC_PER_US cycles after bit 1 rose.
- R4: Bit 0 (output enable) rises exactly LOCK_US*CYC_PER_US cycles after bit 2 rose.
- R5: Order holds at every cycle. Bit 2 is high only while bit 1 is high. Bit 0 is high only while bit 2 is high.
- R6: A disable request sampled at an edge clears all four control bits and `ready_o` at that edge.
- R7: A disable request during either dwell aborts the bring-up. The outputs stay at zero until a new enable arrives. That new enable restarts the full timing.
- R8: An enable request during a dwell or in the on state is ignored. Dwell timing is not restarted, and the on-state outputs are unchanged.
- R9: Bit 3 (test mode) is never set by the sequencer.
- R10: When enable and disable are requested in the same cycle, the disable takes effect.
- R11: `ready_o` is high exactly when the sequencer is fully on, that is, when control bits 2..0 are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-rate control clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_req_i | input | 1 | Start bring-up (one-cycle request) |
| dis_req_i | input | 1 | Shut down or abort (one-cycle request) |
| pll_ctl_o | output | 4 | PLL control word: bit0 output enable, bit1 bypass-off, bit2 reset release (active-low reset), bit3 test mode |
| ready_o | output | 1 | PLL fully on |

## Verification
The bench builds the block with CYC_PER_US=2 and the default dwells of 10 µs and 50 µs. This gives a 20-cycle bypass dwell and a 100-cycle lock dwell. At those lengths the bench can check each dwell edge cycle-exactly. It can also land an abort inside each dwell and a repeated enable partway through the bypass dwell. The checker's dwell counters then track the same windows with no unrolling.

// File: rtl/pll_pwrseq_pkg.sv
package pll_pwrseq_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF    = 2'd0,
        SEQ_BYPASS = 2'd1,
        SEQ_LOCK   = 2'd2,
        SEQ_ON     = 2'd3
    } seq_state_e;

    // Packed so that bit positions match the PLL control word.
    typedef struct packed {
        logic test_mode;   // bit 3
        logic rst_n;       // bit 2
        logic bypass_off;  // bit 1
        logic out_en;      // bit 0
    } pll_ctl_t;

    localparam int CTL_W = 4;

endpackage

// File: rtl/pll_pwrseq_timer.sv
module pll_pwrseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_reg_t;

    tmr_reg_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired_o = (tmr_q.cnt == '0);

endmodule

// File: rtl/pll_pwrseq_fsm.sv
module pll_pwrseq_fsm
    import pll_pwrseq_pkg::*;
#(
    parameter int               CNT_W     = 8,
    parameter logic [CNT_W-1:0] BYP_LOAD  = '0,
    parameter logic [CNT_W-1:0] LOCK_LOAD = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_req_i,
    input  logic             dis_req_i,
    input  logic             expired_i,
    output seq_state_e       state_nxt_o,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o
);

    typedef struct packed {
        seq_state_e state;
    } fsm_reg_t;

    fsm_reg_t fsm_d, fsm_q;

    always_comb begin
        fsm_d      = fsm_q;
        load_o     = 1'b0;
        load_val_o = BYP_LOAD;
        if (dis_req_i) begin
            fsm_d.state = SEQ_OFF;
        end else begin
            unique case (fsm_q.state)
                SEQ_OFF: begin
                    if (en_req_i) begin
                        fsm_d.state = SEQ_BYPASS;
                        load_o      = 1'b1;
                        load_val_o  = BYP_LOAD;
                    end
                end
                SEQ_BYPASS: begin
                    if (expired_i) begin
                        fsm_d.state = SEQ_LOCK;
                        load_o      = 1'b1;
                        load_val_o  = LOCK_LOAD;
                    end
                end
                SEQ_LOCK: begin
                    if (expired_i) begin
                        fsm_d.state = SEQ_ON;
                    end
                end
                SEQ_ON: begin
                    fsm_d.state = SEQ_ON;
                end
                default: begin
                    fsm_d.state = SEQ_OFF;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fsm_q.state <= SEQ_OFF;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_nxt_o = fsm_d.state;

endmodule

// File: rtl/pll_pwrseq_ctl.sv
module pll_pwrseq_ctl
    import pll_pwrseq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  seq_state_e state_nxt_i,
    output pll_ctl_t   ctl_o,
    output logic       ready_o
);

    typedef struct packed {
        pll_ctl_t ctl;
        logic     ready;
    } out_reg_t;

    out_reg_t out_d, out_q;

    always_comb begin
        out_d = '0;
        unique case (state_nxt_i)
            SEQ_OFF: begin
                out_d = '0;
            end
            SEQ_BYPASS: begin
                out_d.ctl.bypass_off = 1'b1;
            end
            SEQ_LOCK: begin
                out_d.ctl.bypass_off = 1'b1;
                out_d.ctl.rst_n      = 1'b1;
            end
            SEQ_ON: begin
                out_d.ctl.bypass_off = 1'b1;
                out_d.ctl.rst_n      = 1'b1;
                out_d.ctl.out_en     = 1'b1;
                out_d.ready          = 1'b1;
            end
            default: begin
                out_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign ctl_o   = out_q.ctl;
    assign ready_o = out_q.ready;

endmodule

// File: rtl/pll_pwrseq.sv
module pll_pwrseq
    import pll_pwrseq_pkg::*;
#(
    parameter int CYC_PER_US = 19,
    parameter int BYP_US     = 10,
    parameter int LOCK_US    = 50
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_req_i,
    input  logic             dis_req_i,
    output logic [CTL_W-1:0] pll_ctl_o,
    output logic             ready_o
);

    localparam int BYP_CYC  = CYC_PER_US * BYP_US;
    localparam int LOCK_CYC = CYC_PER_US * LOCK_US;
    localparam int MAX_CYC  = (BYP_CYC > LOCK_CYC) ? BYP_CYC : LOCK_CYC;
    localparam int CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] BYP_LOAD  = CNT_W'(BYP_CYC - 1);
    localparam logic [CNT_W-1:0] LOCK_LOAD = CNT_W'(LOCK_CYC - 1);

    seq_state_e       state_nxt;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_load_val;
    logic             tmr_expired;
    pll_ctl_t         ctl;

    pll_pwrseq_fsm #(
        .CNT_W     (CNT_W),
        .BYP_LOAD  (BYP_LOAD),
        .LOCK_LOAD (LOCK_LOAD)
    ) fsm_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .en_req_i    (en_req_i),
        .dis_req_i   (dis_req_i),
        .expired_i   (tmr_expired),
        .state_nxt_o (state_nxt),
        .load_o      (tmr_load),
        .load_val_o  (tmr_load_val)
    );

    pll_pwrseq_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (tmr_load),
        .load_val_i (tmr_load_val),
        .expired_o  (tmr_expired)
    );

    pll_pwrseq_ctl ctl_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .state_nxt_i (state_nxt),
        .ctl_o       (ctl),
        .ready_o     (ready_o)
    );

    assign pll_ctl_o = ctl;

endmodule

// File: rtl/pll_pwrseq_chk.sv
module pll_pwrseq_chk #(
    parameter int CYC_PER_US = 19,
    parameter int BYP_US     = 10,
    parameter int LOCK_US    = 50
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic       en_req_i,
    input logic       dis_req_i,
    input logic [3:0] pll_ctl_o,
    input logic       ready_o
);

    localparam int BYP_CYC  = CYC_PER_US * BYP_US;
    localparam int LOCK_CYC = CYC_PER_US * LOCK_US;
    localparam int MAX_CYC  = (BYP_CYC > LOCK_CYC) ? BYP_CYC : LOCK_CYC;
    localparam int DW_W     = $clog2(MAX_CYC + 2);
    localparam logic [DW_W-1:0] DW_MAX = {DW_W{1'b1}};

    logic [DW_W-1:0] byp_dwell_q;
    logic [DW_W-1:0] lock_dwell_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !pll_ctl_o[1]) begin
            byp_dwell_q <= '0;
        end else if (!pll_ctl_o[2] && byp_dwell_q != DW_MAX) begin
            byp_dwell_q <= byp_dwell_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || !pll_ctl_o[2]) begin
            lock_dwell_q <= '0;
        end else if (!pll_ctl_o[0] && lock_dwell_q != DW_MAX) begin
            lock_dwell_q <= lock_dwell_q + 1'b1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (pll_ctl_o == 4'b0000 && !ready_o)); // R1

    AST_FIRST_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_req_i && !dis_req_i && pll_ctl_o == 4'b0000)
            |=> (pll_ctl_o[1] && !pll_ctl_o[2] && !pll_ctl_o[0])); // R2

    AST_BYP_DWELL: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pll_ctl_o[2]) |-> (byp_dwell_q == DW_W'(BYP_CYC))); // R3

    AST_LOCK_DWELL: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pll_ctl_o[0]) |-> (lock_dwell_q == DW_W'(LOCK_CYC))); // R4

    AST_ORDER_RST: assert property (@(posedge clk_i) disable iff (rst_i)
        pll_ctl_o[2] |-> pll_ctl_o[1]); // R5

    AST_ORDER_OE: assert property (@(posedge clk_i) disable iff (rst_i)
        pll_ctl_o[0] |-> pll_ctl_o[2]); // R5

    AST_DIS_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        dis_req_i |=> (pll_ctl_o == 4'b0000 && !ready_o)); // R6 R10

    AST_ON_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (ready_o && !dis_req_i) |=> (ready_o && $stable(pll_ctl_o))); // R8

    AST_READY_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o == (pll_ctl_o[2:0] == 3'b111)); // R11

endmodule

bind pll_pwrseq pll_pwrseq_chk #(
    .CYC_PER_US (CYC_PER_US),
    .BYP_US     (BYP_US),
    .LOCK_US    (LOCK_US)
) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_req_i  (en_req_i),
    .dis_req_i (dis_req_i),
    .pll_ctl_o (pll_ctl_o),
    .ready_o   (ready_o)
);

// File: tb/pll_pwrseq_tb_top.sv
`timescale 1ns/1ps
module pll_pwrseq_tb_top;

    localparam int CPU = 2;
    localparam int BYP = 10 * CPU;
    localparam int LCK = 50 * CPU;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic       dis = 1'b0;
    logic [3:0] ctl;
    logic       rdy;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    pll_pwrseq #(
        .CYC_PER_US (CPU),
        .BYP_US     (10),
        .LOCK_US    (50)
    ) dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .en_req_i  (en),
        .dis_req_i (dis),
        .pll_ctl_o (ctl),
        .ready_o   (rdy)
    );

    task automatic chk(input string req, input logic [3:0] exp_ctl, input logic exp_rdy);
        total++;
        if (ctl !== exp_ctl || rdy !== exp_rdy) begin
            bad++;
            $display("FAIL %s: ctl=%b rdy=%b expected ctl=%b rdy=%b",
                     req, ctl, rdy, exp_ctl, exp_rdy);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_en();
        en = 1'b1; @(negedge clk); en = 1'b0;
    endtask

    task automatic pulse_dis();
        dis = 1'b1; @(negedge clk); dis = 1'b0;
    endtask

    task automatic t_reset();
        step(3);
        chk("R1 reset state", 4'b0000, 1'b0);
        rst = 1'b0;
        step(2);
        chk("R1 idle after reset", 4'b0000, 1'b0);
    endtask

    task automatic t_full_enable(input string tag);
        pulse_en();
        chk({tag, " R2 bypass-off first"}, 4'b0010, 1'b0);
        step(BYP - 1);
        chk({tag, " R3 reset held to end of dwell"}, 4'b0010, 1'b0);
        step(1);
        chk({tag, " R3 R5 reset released"}, 4'b0110, 1'b0);
        step(LCK - 1);
        chk({tag, " R4 output held to end of lock"}, 4'b0110, 1'b0);
        step(1);
        chk({tag, " R4 R11 R9 fully on"}, 4'b0111, 1'b1);
    endtask

    task automatic t_disable_on();
        pulse_dis();
        chk("R6 one-cycle shutdown", 4'b0000, 1'b0);
        step(5);
        chk("R6 stays off", 4'b0000, 1'b0);
    endtask

    task automatic t_abort_bypass();
        pulse_en();
        step(3);
        pulse_dis();
        chk("R7 abort in bypass dwell", 4'b0000, 1'b0);
        step(BYP + LCK + 5);
        chk("R7 no resume after abort", 4'b0000, 1'b0);
    endtask

    task automatic t_abort_lock();
        pulse_en();
        step(BYP + 5);
        chk("R7 in lock dwell", 4'b0110, 1'b0);
        pulse_dis();
        chk("R7 abort in lock dwell", 4'b0000, 1'b0);
        t_full_enable("R7 restart");
        pulse_dis();
    endtask

    task automatic t_enable_ignored();
        pulse_en();
        step(4);
        pulse_en();
        step(BYP - 1 - 5);
        chk("R8 timing not restarted (hold)", 4'b0010, 1'b0);
        step(1);
        chk("R8 timing not restarted (release)", 4'b0110, 1'b0);
        step(LCK);
        chk("R8 reaches on", 4'b0111, 1'b1);
        pulse_en();
        chk("R8 enable while on ignored", 4'b0111, 1'b1);
        step(3);
        chk("R8 still on", 4'b0111, 1'b1);
    endtask

    task automatic t_both();
        en = 1'b1; dis = 1'b1; @(negedge clk); en = 1'b0; dis = 1'b0;
        chk("R10 both while on", 4'b0000, 1'b0);
        en = 1'b1; dis = 1'b1; @(negedge clk); en = 1'b0; dis = 1'b0;
        chk("R10 both while off", 4'b0000, 1'b0);
        step(3);
        chk("R10 no start", 4'b0000, 1'b0);
    endtask

    task automatic t_sync_reset();
        t_full_enable("R1 pre");
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R1 reset while on", 4'b0000, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_full_enable("main");
        t_disable_on();
        t_abort_bypass();
        t_abort_lock();
        t_enable_ignored();
        t_both();
        t_sync_reset();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule